// File: doc/BRIEF.md
# Transport Stream Output Formatter

This block sits at the end of a cable demodulator's error-correction chain. It takes decoded 188-byte transport packets one byte at a time, with a start-of-packet marker on the first byte and a per-packet flag saying the decoder could not repair it. It presents each byte to the outside world with a byte clock, a data-enable, a packet-sync pulse and an uncorrectable indication. The output is either a full byte on eight data lines or a bit stream on data line 0.

Each byte becomes one or eight output slots. A slot lasts two system clocks. In the first, the outputs take their new values with the output clock low. In the second, the output clock is high, so a receiver samples on the rising edge and the block only moves its outputs on the falling edge. A packet flagged as uncorrectable is passed through unchanged, with one exception: the top bit of its second byte (the transport error indicator) is set, unless software has disabled that marking.

The input is a valid/ready stream. A byte transfers on a rising clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the source must hold the byte, the marker and the flag stable. `in_ready` is high when the block is idle, and during the high phase of the last slot of the current byte, so back-to-back bytes leave no idle gap. The mode and disable bits may only be changed while `ts_en` is low.

Top module: `ts_out_formatter`

## Requirements
- R1: After reset, `ts_en`, `ts_clk`, `ts_sync` and `ts_uncor` are low, and `in_ready` is high.
- R2: In parallel mode (`cfg_serial`=0), every accepted byte appears on `ts_data[7:0]` with `ts_en` high for exactly one slot: one system clock with `ts_clk` low, then one with `ts_clk` high. Bytes appear in acceptance order, and `in_ready` is low during the low phase of a slot.
- R3: The outputs change only in a cycle where `ts_clk` is low. At each rising edge of `ts_clk`, `ts_data`, `ts_sync` and `ts_uncor` hold the values of the preceding cycle.
- R4: In serial mode (`cfg_serial`=1), each byte is sent MSB first on `ts_data[0]` as eight slots with one `ts_clk` pulse each. `ts_data[7:1]` stay 0, and no new byte is accepted until the high phase of the eighth slot.
- R5: `ts_sync` is high for every slot of a byte accepted with `in_sop`=1 (byte index 0), and low for every other byte.
- R6: `ts_uncor` is high for every slot of every byte of a packet whose start byte carried `in_uncor`=1. It stays with that packet until the next `in_sop`.
- R7: When the packet is flagged and `cfg_flag_dis`=2'b00, the byte at index 1 is output with bit 7 forced to 1 and bits 6:0 unchanged.
- R8: If either bit of `cfg_flag_dis` is 1, the index-1 byte of a flagged packet is output unchanged. All other bytes are always output unchanged.
- R9: When no byte is in flight, `ts_clk`, `ts_en`, `ts_sync` and `ts_uncor` stay low.
- R10: The byte index restarts at 0 on every byte with `in_sop`=1, however many bytes came before. Without a marker it counts up to 187 and holds there, so no sync and no marking happen at the held index. Before the first marker after reset, the index holds at 187.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Decoded packet byte |
| in_sop | input | 1 | Byte is the first of a packet |
| in_uncor | input | 1 | Packet is uncorrectable (sampled with in_sop) |
| cfg_serial | input | 1 | 0: parallel output, 1: serial output on bit 0 |
| cfg_flag_dis | input | 2 | Error-indicator marking happens only when both bits are 0 |
| ts_data | output | 8 | Output data bus |
| ts_clk | output | 1 | Output byte/bit clock, receiver samples on rise |
| ts_en | output | 1 | Output data valid |
| ts_sync | output | 1 | High during the packet's first byte |
| ts_uncor | output | 1 | High during every byte of an uncorrectable packet |

## Verification
Two pairs of events can fall in the same system clock. A new byte can be accepted in the very cycle the previous byte's last slot shows its high clock phase. A start marker can also land while the index counter is short of a full packet, or has saturated. The sweep drives every mode, both flag states and all four disable settings, with packets that are mostly back-to-back and have a few idle gaps. It then sends short packets restarted early and a long run without a marker. Each reconstructed byte, with its sync and uncorrectable levels, is compared with a model that works out the index, the latched flag and the bit-7 override from the rules above.

// File: rtl/ts_fmt_pkg.sv
package ts_fmt_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              sync;
    logic              uncor;
  } ts_beat_t;
endpackage

// File: rtl/ts_pkt_tracker.sv
module ts_pkt_tracker
  import ts_fmt_pkg::*;
#(
  parameter int PKT_LEN  = 188,
  parameter int HDR_POS  = 1,
  parameter int FLAG_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              sop,
  input  logic              uncor_in,
  input  logic [1:0]        flag_dis,
  output ts_beat_t          beat
);
  localparam int              CW   = $clog2(PKT_LEN);
  localparam logic [CW-1:0]   LAST = CW'(PKT_LEN - 1);
  localparam logic [CW-1:0]   HDR  = CW'(HDR_POS);

  logic [CW-1:0] idx_q, idx_d;
  logic          unc_q, unc_d;

  // index of the byte being offered, counting from the start marker
  always_comb begin
    if (sop)                idx_d = '0;
    else if (idx_q == LAST) idx_d = LAST;
    else                    idx_d = idx_q + 1'b1;
    unc_d = sop ? uncor_in : unc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= LAST;
      unc_q <= 1'b0;
    end else if (take) begin
      idx_q <= idx_d;
      unc_q <= unc_d;
    end
  end

  logic mark;
  assign mark = unc_d && (flag_dis == 2'b00) && (idx_d == HDR);

  always_comb begin
    beat                = '0;
    beat.data           = byte_in;
    beat.data[FLAG_BIT] = byte_in[FLAG_BIT] | mark;
    beat.sync           = (idx_d == '0);
    beat.uncor          = unc_d;
  end
endmodule

// File: rtl/ts_serializer.sv
module ts_serializer
  import ts_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serial_mode,
  input  logic              beat_valid,
  input  ts_beat_t          beat,
  output logic              beat_ready,
  output logic [BYTE_W-1:0] ts_data,
  output logic              ts_clk,
  output logic              ts_en,
  output logic              ts_sync,
  output logic              ts_uncor
);
  localparam int BC_W = $clog2(BYTE_W);

  logic              busy_q, phase_q, ser_q, sync_q, unc_q;
  logic [BC_W-1:0]   left_q;
  logic [BYTE_W-1:0] sh_q;
  logic              last_slot, take;

  assign last_slot  = busy_q && phase_q && (left_q == '0);
  assign beat_ready = !busy_q || last_slot;
  assign take       = beat_valid && beat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      ser_q   <= 1'b0;
      sync_q  <= 1'b0;
      unc_q   <= 1'b0;
      left_q  <= '0;
      sh_q    <= '0;
    end else if (take) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      ser_q   <= serial_mode;
      sync_q  <= beat.sync;
      unc_q   <= beat.uncor;
      left_q  <= serial_mode ? BC_W'(BYTE_W - 1) : '0;
      sh_q    <= beat.data;
    end else if (busy_q) begin
      if (!phase_q) begin
        phase_q <= 1'b1;
      end else if (left_q != '0) begin
        phase_q <= 1'b0;
        left_q  <= left_q - 1'b1;
        sh_q    <= {sh_q[BYTE_W-2:0], 1'b0};
      end else begin
        busy_q  <= 1'b0;
        phase_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
    if (i == 0) begin : g_lsb
      assign ts_data[i] = busy_q && (ser_q ? sh_q[BYTE_W-1] : sh_q[0]);
    end else begin : g_rest
      assign ts_data[i] = busy_q && !ser_q && sh_q[i];
    end
  end

  assign ts_clk   = busy_q && phase_q;
  assign ts_en    = busy_q;
  assign ts_sync  = busy_q && sync_q;
  assign ts_uncor = busy_q && unc_q;
endmodule

// File: rtl/ts_out_formatter.sv
module ts_out_formatter
  import ts_fmt_pkg::*;
#(
  parameter int PKT_LEN = 188
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_uncor,
  input  logic        cfg_serial,
  input  logic [1:0]  cfg_flag_dis,
  output logic [7:0]  ts_data,
  output logic        ts_clk,
  output logic        ts_en,
  output logic        ts_sync,
  output logic        ts_uncor
);
  ts_beat_t beat;
  logic     take;

  assign take = in_valid && in_ready;

  ts_pkt_tracker #(.PKT_LEN(PKT_LEN)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .byte_in  (in_data),
    .sop      (in_sop),
    .uncor_in (in_uncor),
    .flag_dis (cfg_flag_dis),
    .beat     (beat)
  );

  ts_serializer u_ser (
    .clk         (clk),
    .rst_n       (rst_n),
    .serial_mode (cfg_serial),
    .beat_valid  (in_valid),
    .beat        (beat),
    .beat_ready  (in_ready),
    .ts_data     (ts_data),
    .ts_clk      (ts_clk),
    .ts_en       (ts_en),
    .ts_sync     (ts_sync),
    .ts_uncor    (ts_uncor)
  );
endmodule

// File: rtl/ts_fmt_checker.sv
module ts_fmt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       cfg_serial,
  input logic [7:0] ts_data,
  input logic       ts_clk,
  input logic       ts_en,
  input logic       ts_sync,
  input logic       ts_uncor
);
  p_clk_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clk |-> ts_en);

  p_flags_need_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_sync || ts_uncor) |-> ts_en);

  p_single_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ts_clk |=> !ts_clk);

  p_busy_low_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ts_en && !ts_clk) |-> !in_ready);

  p_hold_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ts_clk) |-> ($stable(ts_data) && $stable(ts_sync) && $stable(ts_uncor)));

  p_serial_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_serial && ts_en) |-> (ts_data[7:1] == 7'd0));
endmodule

bind ts_out_formatter ts_fmt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .cfg_serial (cfg_serial),
  .ts_data    (ts_data),
  .ts_clk     (ts_clk),
  .ts_en      (ts_en),
  .ts_sync    (ts_sync),
  .ts_uncor   (ts_uncor)
);

// File: tb/ts_out_formatter_bench.sv
module ts_out_formatter_bench;
  localparam int L = 188;
  localparam int QD = 4096;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_uncor = 0, cfg_serial = 0;
  logic [7:0] in_data = 0;
  logic [1:0] cfg_flag_dis = 0;
  logic in_ready, ts_clk, ts_en, ts_sync, ts_uncor;
  logic [7:0] ts_data;

  always #4 clk = ~clk;

  ts_out_formatter u_ts_out_formatter (.*);

  int errs = 0, checks = 0, cycles = 0;
  logic [7:0] q_byte [QD];
  logic       q_sync [QD];
  logic       q_unc  [QD];
  int wr = 0, rd = 0;
  int m_idx = L - 1;
  logic m_unc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // expected model from the requirements (R5 R6 R7 R8 R10)
  task automatic send(input logic [7:0] b, input logic sop, input logic unc);
    logic [7:0] eb;
    if (sop) m_idx = 0; else if (m_idx != L - 1) m_idx++;
    if (sop) m_unc = unc;
    eb = b;
    if (m_idx == 1 && m_unc && cfg_flag_dis == 2'b00) eb[7] = 1'b1;
    q_byte[wr % QD] = eb; q_sync[wr % QD] = (m_idx == 0); q_unc[wr % QD] = m_unc;
    wr++;
    in_valid = 1; in_data = b; in_sop = sop; in_uncor = unc;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_uncor = 0;
  endtask

  task automatic drain();
    while (rd != wr || ts_en) @(negedge clk);
  endtask

  // monitor: one capture per high phase of ts_clk
  logic [7:0] prev_data = 0;
  logic prev_sync = 0, prev_unc = 0;
  int nbit = 0;
  logic [7:0] acc = 0;
  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      finish_run();
    end
    if (rst_n && ts_clk) begin
      chk(ts_data == prev_data && ts_sync == prev_sync && ts_uncor == prev_unc,
          "R3 hold at rise", ts_data, prev_data);
      chk(rd != wr, "R2 unexpected pulse", rd, wr);
      chk(ts_sync == q_sync[rd % QD], "R5 sync", ts_sync, q_sync[rd % QD]);
      chk(ts_uncor == q_unc[rd % QD], "R6 uncor", ts_uncor, q_unc[rd % QD]);
      if (cfg_serial) begin
        chk(ts_data[7:1] == 0, "R4 upper lines", ts_data, 0);
        acc = {acc[6:0], ts_data[0]};
        nbit++;
        if (nbit == 8) begin
          chk(acc == q_byte[rd % QD], "R4 R7 R8 serial byte", acc, q_byte[rd % QD]);
          nbit = 0; rd++;
        end
      end else begin
        chk(ts_data == q_byte[rd % QD], "R2 R7 R8 parallel byte", ts_data, q_byte[rd % QD]);
        rd++;
      end
    end
    prev_data = ts_data; prev_sync = ts_sync; prev_unc = ts_uncor;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ts_en && !ts_clk && !ts_sync && !ts_uncor, "R1 outputs in reset",
        {ts_en, ts_clk, ts_sync, ts_uncor}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1 ready after reset", in_ready, 1);
    // R10: bytes before any marker hold at the last index
    send(8'hC3, 0, 0);
    send(8'h11, 0, 0);
    drain();
    for (int c = 0; c < 16; c++) begin
      cfg_serial   = c[3];
      cfg_flag_dis = c[2:1];
      @(negedge clk);
      for (int k = 0; k < L; k++) begin
        send(k == 0 ? 8'h47 : 8'((k * 37 + c * 11) & 255), k == 0, c[0]);
        if (k % 41 == 7) @(negedge clk);
      end
      drain();
      // R9 idle
      repeat (3) begin
        @(negedge clk);
        chk(!ts_clk && !ts_en && !ts_sync && !ts_uncor, "R9 idle",
            {ts_clk, ts_en, ts_sync, ts_uncor}, 0);
      end
    end
    // R10: early restart and saturation in parallel mode, marking on
    cfg_serial = 0; cfg_flag_dis = 0;
    @(negedge clk);
    send(8'h47, 1, 1); send(8'h05, 0, 0); send(8'h22, 0, 0);
    send(8'h47, 1, 1); send(8'h06, 0, 0);
    send(8'h47, 1, 0); send(8'h07, 0, 1);
    send(8'h47, 1, 1);
    for (int k = 1; k < L + 4; k++) send(8'(k & 127), 0, 0);
    send(8'h47, 1, 0); send(8'h01, 0, 0);
    drain();
    chk(rd == wr, "R2 all bytes delivered", rd, wr);
    chk(nbit == 0, "R4 no partial byte", nbit, 0);
    finish_run();
  end
endmodule